// File: doc/BRIEF.md
# Vector XOR-and-Rotate Execution Unit

This unit takes one 32-bit instruction word at a time. When the word carries the XOR-and-rotate opcode, the unit reads two 128-bit registers from its own 32-entry register file. It XORs them across the full width. It then splits the result into two 64-bit lanes and rotates each lane right by a 6-bit immediate taken from the instruction. The rotated value goes back to a destination register, and a done strobe pulses.

Two enable inputs guard execution. The first says whether the instruction exists on this machine at all. If it is low, a matching word raises an undefined strobe. The second says whether the vector unit is switched on. If it is low, a matching word raises a disabled-trap strobe. In both cases no register is written. The datapath is a fixed barrel rotator, so every operand value and every rotate amount takes the same single cycle.

A preload port and a combinational read-back port give direct access to the register file. They let the file be loaded before a run and inspected afterwards.

Top module: `xr_exec_unit`

## Requirements
- R1: After reset the three strobes are low and every register reads back as zero.
- R2: A word is accepted only when `insn_valid` is high and bits [31:21] equal 11001110100. Any other word, or any word with `insn_valid` low, raises no strobe and changes no register.
- R3: The operand fields sit at fixed positions: the second source index at bits [20:16], the rotate amount at [15:10], the first source index at [9:5] and the destination index at [4:0].
- R4: The destination receives {ror(X[127:64], amt), ror(X[63:0], amt)}, where X is the bitwise XOR of the two sources. No bit crosses between the lanes.
- R5: An amount of 0 leaves each lane unchanged. An amount of 63 equals a left rotate of each lane by one.
- R6: With `feat_en` low, a matching valid word pulses `undef_o` in the next cycle and writes nothing. This takes priority over `vec_en`.
- R7: With `feat_en` high and `vec_en` low, a matching valid word pulses `trap_o` in the next cycle and writes nothing.
- R8: With both enables high, `done_o` pulses in the cycle after the word is sampled. The destination holds the result from that same edge. This latency is the same for all data and all amounts.
- R9: When the destination equals a source, the pre-write value of that source is used. A following instruction issued in the very next cycle sees the newly written value.
- R10: `pre_we` writes `pre_data` to `pre_addr`. If an executing instruction writes in the same cycle, the instruction's write wins and the preload is dropped. `rb_data` always shows the entry at `rb_addr`.
- R11: At most one of the three strobes is high in any cycle, and each lasts one cycle per accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction word present |
| insn_word | input | 32 | Instruction word |
| feat_en | input | 1 | Instruction is implemented |
| vec_en | input | 1 | Vector unit switched on |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 5 | Preload register index |
| pre_data | input | 128 | Preload value |
| rb_addr | input | 5 | Read-back register index |
| rb_data | output | 128 | Read-back value (combinational) |
| done_o | output | 1 | Instruction completed and written |
| undef_o | output | 1 | Matching word but instruction absent |
| trap_o | output | 1 | Matching word while vector unit is off |

## Verification
Every result of this block is due exactly one clock edge after the word is sampled. The strobes are visible in the following cycle, and the destination register reads back its new value from that same edge onward. The bench drives each word at a falling edge and samples the strobes at the next falling edge. It reads the register file only after deasserting `insn_valid`, so the read-back is never mid-update. Back-to-back words are issued on consecutive falling edges to show that the second one already sees the first one's write.

// File: rtl/xr_pkg.sv
package xr_pkg;

    localparam int            XR_OPC_W  = 11;
    localparam logic [10:0]   XR_OPCODE = 11'b11001110100;
    localparam int            XR_IDX_W  = 5;
    localparam int            XR_AMT_W  = 6;

    typedef struct packed {
        logic                hit;
        logic [XR_IDX_W-1:0] dst;
        logic [XR_IDX_W-1:0] src_a;
        logic [XR_IDX_W-1:0] src_b;
        logic [XR_AMT_W-1:0] amt;
    } xr_dec_t;

    typedef struct packed {
        logic done;
        logic undef;
        logic trap;
    } xr_flags_t;

endpackage

// File: rtl/xr_decode.sv
module xr_decode
    import xr_pkg::*;
(
    input  logic [31:0] insn_i,
    output xr_dec_t     dec_o
);
    // Field positions are fixed by the encoding.
    always_comb begin
        dec_o.hit   = (insn_i[31:21] == XR_OPCODE);
        dec_o.src_b = insn_i[20:16];
        dec_o.amt   = insn_i[15:10];
        dec_o.src_a = insn_i[9:5];
        dec_o.dst   = insn_i[4:0];
    end
endmodule

// File: rtl/xr_lane_rot.sv
module xr_lane_rot #(
    parameter  int LANE_W = 64,
    parameter  int LANES  = 2,
    localparam int AMT_W  = $clog2(LANE_W),
    localparam int VEC_W  = LANE_W * LANES
) (
    input  logic [VEC_W-1:0] vec_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [VEC_W-1:0] vec_o
);
    // One log-depth barrel per lane: each stage applies a fixed power-of-two
    // rotate or passes through, so depth never depends on the amount.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] stage [AMT_W+1];
        assign stage[0] = vec_i[l*LANE_W +: LANE_W];
        for (genvar s = 0; s < AMT_W; s++) begin : g_stage
            localparam int SH = 1 << s;
            assign stage[s+1] = amt_i[s]
                ? {stage[s][SH-1:0], stage[s][LANE_W-1:SH]}
                : stage[s];
        end
        assign vec_o[l*LANE_W +: LANE_W] = stage[AMT_W];
    end
endmodule

// File: rtl/xr_regfile.sv
module xr_regfile #(
    parameter  int DEPTH = 32,
    parameter  int WIDTH = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_addr,
    output logic [WIDTH-1:0] ra_data,
    input  logic [IDX_W-1:0] rb_addr,
    output logic [WIDTH-1:0] rb_data,
    input  logic [IDX_W-1:0] rc_addr,
    output logic [WIDTH-1:0] rc_data,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];
    assign rc_data = mem_q[rc_addr];
endmodule

// File: rtl/xr_exec_unit.sv
module xr_exec_unit
    import xr_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    parameter  int LANE_W   = 64,
    parameter  int LANES    = 2,
    localparam int VEC_W    = LANE_W * LANES,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int AMT_W    = $clog2(LANE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_valid,
    input  logic [31:0]      insn_word,
    input  logic             feat_en,
    input  logic             vec_en,
    input  logic             pre_we,
    input  logic [IDX_W-1:0] pre_addr,
    input  logic [VEC_W-1:0] pre_data,
    input  logic [IDX_W-1:0] rb_addr,
    output logic [VEC_W-1:0] rb_data,
    output logic             done_o,
    output logic             undef_o,
    output logic             trap_o
);
    xr_dec_t          dec;
    xr_flags_t        flags_d, flags_q;
    logic [VEC_W-1:0] src_a_val, src_b_val, xor_val, rot_val;
    logic             exec_we_d;
    logic             wr_en;
    logic [IDX_W-1:0] wr_addr;
    logic [VEC_W-1:0] wr_data;

    xr_decode u_dec (
        .insn_i (insn_word),
        .dec_o  (dec)
    );

    xr_regfile #(.DEPTH(NUM_REGS), .WIDTH(VEC_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (IDX_W'(dec.src_a)),
        .ra_data (src_a_val),
        .rb_addr (IDX_W'(dec.src_b)),
        .rb_data (src_b_val),
        .rc_addr (rb_addr),
        .rc_data (rb_data),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data)
    );

    assign xor_val = src_a_val ^ src_b_val;

    xr_lane_rot #(.LANE_W(LANE_W), .LANES(LANES)) u_rot (
        .vec_i (xor_val),
        .amt_i (AMT_W'(dec.amt)),
        .vec_o (rot_val)
    );

    // Next-state: feature check first, then unit enable, then execute.
    always_comb begin
        flags_d   = '0;
        exec_we_d = 1'b0;
        if (insn_valid && dec.hit) begin
            if (!feat_en) begin
                flags_d.undef = 1'b1;
            end else if (!vec_en) begin
                flags_d.trap = 1'b1;
            end else begin
                flags_d.done = 1'b1;
                exec_we_d    = 1'b1;
            end
        end
    end

    // Single write port: instruction result has priority over preload.
    always_comb begin
        wr_en   = exec_we_d | pre_we;
        wr_addr = exec_we_d ? IDX_W'(dec.dst) : pre_addr;
        wr_data = exec_we_d ? rot_val : pre_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign done_o  = flags_q.done;
    assign undef_o = flags_q.undef;
    assign trap_o  = flags_q.trap;

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, undef_o, trap_o}));

    assert_nomatch_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!insn_valid || !dec.hit) |=> !(done_o || undef_o || trap_o));

    assert_undef_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && dec.hit && !feat_en) |=> (undef_o && !done_o));

    assert_trap_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && dec.hit && feat_en && !vec_en) |=> (trap_o && !done_o));

    assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && dec.hit && feat_en && vec_en) |=> done_o);

    assert_rot_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.amt == '0) |-> (rot_val == xor_val));

    assert_rot_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (AMT_W'(dec.amt) == AMT_W'(LANE_W - 1)) |->
        (rot_val[LANE_W-1:0] == {xor_val[LANE_W-2:0], xor_val[LANE_W-1]}));
endmodule

// File: tb/tb_xr_exec_unit.sv
`timescale 1ns/100ps
module tb_xr_exec_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         insn_valid = 1'b0;
    logic [31:0]  insn_word = '0;
    logic         feat_en = 1'b1;
    logic         vec_en = 1'b1;
    logic         pre_we = 1'b0;
    logic [4:0]   pre_addr = '0;
    logic [127:0] pre_data = '0;
    logic [4:0]   rb_addr = '0;
    logic [127:0] rb_data;
    logic         done_o, undef_o, trap_o;

    logic [127:0] model [32];
    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    xr_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .feat_en(feat_en), .vec_en(vec_en), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .rb_addr(rb_addr), .rb_data(rb_data),
        .done_o(done_o), .undef_o(undef_o), .trap_o(trap_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [63:0] ror64(logic [63:0] x, int n);
        return (x >> n) | (x << (64 - n));
    endfunction

    function automatic logic [127:0] ref_op(logic [127:0] a, logic [127:0] b, int n);
        logic [127:0] x = a ^ b;
        return {ror64(x[127:64], n), ror64(x[63:0], n)};
    endfunction

    function automatic logic [31:0] mk(int rd, int rn, int rm, int amt);
        return {11'b11001110100, 5'(rm), 6'(amt), 5'(rn), 5'(rd)};
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_reg(int idx, string req);
        rb_addr = 5'(idx);
        #1;
        chk(req, rb_data, model[idx]);
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 32; i++) check_reg(i, req);
    endtask

    // Called at a falling edge; samples strobes at the next falling edge.
    task automatic exec(logic [31:0] w, logic fe, logic ve, logic vld, string req);
        logic       hit = (w[31:21] == 11'b11001110100) && vld;
        logic [2:0] exp;
        logic [127:0] res;
        insn_word  = w;
        feat_en    = fe;
        vec_en     = ve;
        insn_valid = vld;
        res = ref_op(model[w[9:5]], model[w[20:16]], int'(w[15:10]));
        exp = !hit ? 3'b000 : !fe ? 3'b010 : !ve ? 3'b001 : 3'b100;
        @(negedge clk);
        chk(req, {125'd0, done_o, undef_o, trap_o}, {125'd0, exp});
        if (exp == 3'b100) model[w[4:0]] = res;
    endtask

    task automatic idle();
        insn_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 strobes", {125'd0, done_o, undef_o, trap_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 regs zero");

        // R10 preload and readback
        for (int i = 0; i < 32; i++) begin
            pre_we = 1'b1; pre_addr = 5'(i); pre_data = rnd128(); model[i] = pre_data;
            @(negedge clk);
        end
        pre_we = 1'b0;
        check_all("R10 preload");

        // R5 amount 0 and 63
        exec(mk(3, 1, 2, 0), 1, 1, 1, "R5 amt0 done"); idle(); check_reg(3, "R5 amt0");
        exec(mk(4, 5, 6, 63), 1, 1, 1, "R5 amt63 done"); idle(); check_reg(4, "R5 amt63");
        exec(mk(7, 8, 9, 32), 1, 1, 1, "R4 amt32 done"); idle(); check_reg(7, "R4 amt32");
        exec(mk(10, 11, 12, 1), 1, 1, 1, "R4 amt1 done"); idle(); check_reg(10, "R4 amt1");

        // R9 dst aliases source, then same source on both sides
        exec(mk(13, 13, 14, 17), 1, 1, 1, "R9 alias done"); idle(); check_reg(13, "R9 alias rn");
        exec(mk(15, 16, 15, 40), 1, 1, 1, "R9 alias rm done"); idle(); check_reg(15, "R9 alias rm");
        exec(mk(18, 18, 18, 5), 1, 1, 1, "R9 self done"); idle(); check_reg(18, "R9 self zero");

        // R9 back-to-back dependency
        exec(mk(20, 21, 22, 9), 1, 1, 1, "R9 b2b first");
        exec(mk(23, 20, 24, 50), 1, 1, 1, "R9 b2b second");
        idle(); check_reg(20, "R9 b2b r20"); check_reg(23, "R9 b2b r23");

        // R6 feature off (also with vec off: undef wins), R7 vec off
        exec(mk(25, 1, 2, 3), 0, 1, 1, "R6 undef"); idle(); check_all("R6 no write");
        exec(mk(25, 1, 2, 3), 0, 0, 1, "R6 undef priority"); idle();
        exec(mk(26, 1, 2, 3), 1, 0, 1, "R7 trap"); idle(); check_all("R7 no write");

        // R2 non-matching words and valid low
        exec(mk(27, 1, 2, 3) ^ 32'h0020_0000, 1, 1, 1, "R2 bit21");
        exec(mk(27, 1, 2, 3) ^ 32'h8000_0000, 1, 1, 1, "R2 bit31");
        exec(mk(27, 1, 2, 3), 1, 1, 0, "R2 valid low");
        idle(); check_all("R2 no write");

        // R10 preload collides with instruction write
        pre_we = 1'b1; pre_addr = 5'd28; pre_data = rnd128();
        exec(mk(28, 29, 30, 11), 1, 1, 1, "R10 collide done");
        pre_we = 1'b0; idle(); check_reg(28, "R10 collide");
        pre_we = 1'b1; pre_addr = 5'd31; pre_data = rnd128();
        exec(mk(31, 1, 2, 3), 1, 1, 0, "R10 preload with idle word");
        model[31] = pre_data; pre_we = 1'b0; idle(); check_reg(31, "R10 preload lands");

        // R3 R4 R8 random operations
        for (int k = 0; k < 300; k++) begin
            int rd = int'($urandom_range(0, 31));
            int rn = int'($urandom_range(0, 31));
            int rm = int'($urandom_range(0, 31));
            int am = int'($urandom_range(0, 63));
            logic fe = ($urandom_range(0, 9) != 0);
            logic ve = ($urandom_range(0, 9) != 0);
            exec(mk(rd, rn, rm, am), fe, ve, 1, "R8 strobe");
            if ($urandom_range(0, 3) == 0) exec(mk(rn, rd, rm, 63 - am), 1, 1, 1, "R8 b2b");
            idle();
            check_reg(rd, "R3 R4 result");
            if (k % 50 == 0) check_all("R4 regfile");
        end
        check_all("R4 final");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule